// File: doc/BRIEF.md
# Guarded Control and Status Register File

A byte-wide register file that sits behind a simple strobe interface: a write strobe and a read strobe share one address bus, writes carry a data byte, and reads return a byte one clock later on a registered output. A separate end-of-frame pulse reports how many serial clocks the last access frame contained. Around the storage, the block keeps a status register of sticky flags. Write-one-to-clear removes these flags. Results from a link CRC engine, a configuration CRC engine, a supply monitor and the conversion core arrive as single-cycle pulses. The block itself judges two conditions: whether an access address lies in the decoded range, and whether a frame length is a whole number of bytes.

When the link CRC flag, the address flag or the frame-length flag is set, the block refuses every write except a write to the status register. Software must therefore acknowledge the fault before it can change configuration again. A control register carries a six-bit software reset key and two self-clearing command bits, start and stop. Each command bit becomes a one-cycle pulse at the block edge. Per-channel register groups repeat at a fixed stride, and the channel count is a parameter.

Top module: `guarded_regfile`

## Requirements
- R1: After power-on reset the status register (02h) reads 60h, register 09h reads 04h, register 0Ah reads 80h, the gain high byte of every channel (channel base 11h plus 8·n plus 5) reads 40h, and every other stored register reads 00h. Addresses 00h and 01h return the identity and revision parameters.
- R2: A write to a stored register (05h, 06h, 08h..10h, 11h..50h) takes effect at the clock edge that samples it. A read strobe presents the addressed byte on rdata after the next clock edge, and rdata holds it until the next read.
- R3: Addresses 03h and 04h read 00h and discard writes. Addresses above 50h read 00h.
- R4: Status bits 6, 5, 4, 3, 1 and 0 stay set until a status write has a 1 in that position. Writing 0 leaves them unchanged. A set event in the same cycle as the clearing write wins.
- R5: Status bit 2 (conversion fault) cannot be cleared by a status write; only a power-on or software reset clears it. Status bit 7 always reads 0.
- R6: An event pulse sets its status bit: supply low sets bit 6, link CRC sets bit 4, configuration CRC sets bit 3, and conversion fault sets bit 2.
- R7: When bit 3 of register 0Ah is 1, a read or write to an address above 50h sets status bit 1. When bit 3 is 0, no flag is set.
- R8: When bit 2 of register 0Ah is 1, an end-of-frame pulse whose clock count is not a multiple of eight sets status bit 0.
- R9: While status bit 4, 1 or 0 is set, writes to every address except 02h are ignored, including the control register. Status bit 3 alone does not block writes.
- R10: A write of 58h to control register 07h (key 010110b in bits 7:2, bits 1:0 zero) restores every reset value of R1, with the status reading 60h. A key written with bit 1 or bit 0 set does not reset.
- R11: A 1 written to bit 1 or bit 0 of 07h gives a one-cycle pulse on start_pulse or stop_pulse in the cycle after the write. Register 07h always reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| frame_bits | input | CNT_W | Serial clock count of the ending frame |
| ev_supply_low | input | 1 | Supply low event pulse |
| ev_link_crc | input | 1 | Link CRC failure pulse |
| ev_cfg_crc | input | 1 | Configuration CRC failure pulse |
| ev_conv_fault | input | 1 | Internal conversion fault pulse |
| start_pulse | output | 1 | Start command pulse |
| stop_pulse | output | 1 | Stop command pulse |
| regs_flat | output | (LAST+1)·8 | All stored bytes, byte a at bits a·8+7..a·8 |

## Verification
The hardest situation to reach is the write lock: configuration must still hold its old value after a refused write, and the refusal must also cover the control register, so no start pulse and no software reset may follow. The stimulus first enables the checks through 0Ah, provokes each guarding flag with an out-of-range read, a short frame or a link CRC pulse, and attempts configuration and command writes. It then clears the flag through the status register and repeats the write to show that it is accepted. A clearing write that coincides with a new supply-low pulse covers the set-over-clear priority.

// File: rtl/rf_pkg.sv
package rf_pkg;

   localparam int AW = 8;

   localparam logic [AW-1:0] A_ID    = 8'h00;
   localparam logic [AW-1:0] A_REV   = 8'h01;
   localparam logic [AW-1:0] A_STAT  = 8'h02;
   localparam logic [AW-1:0] A_CTRL  = 8'h07;
   localparam logic [AW-1:0] A_GCFG2 = 8'h09;
   localparam logic [AW-1:0] A_GCFG3 = 8'h0A;

   localparam int CRC_HI_A = 5;
   localparam int CRC_LO_A = 6;
   localparam int GEN_LO_A = 8;
   localparam int GEN_HI_A = 16;

   localparam int CHK_ADDR_BIT = 3;
   localparam int CHK_LEN_BIT  = 2;

   localparam logic [5:0] SW_KEY = 6'b010110;

   localparam logic [7:0] STAT_RST  = 8'h60;
   localparam logic [7:0] GCFG2_RST = 8'h04;
   localparam logic [7:0] GCFG3_RST = 8'h80;
   localparam logic [7:0] GAIN_RST  = 8'h40;

   typedef struct packed {
      logic rsvd;
      logic supply_low;
      logic rst_seen;
      logic link_crc;
      logic cfg_crc;
      logic conv_fault;
      logic addr_bad;
      logic len_bad;
   } stat_t;

endpackage

// File: rtl/rf_guard.sv
module rf_guard
   import rf_pkg::*;
#(
   parameter int LAST  = 80,
   parameter int CNT_W = 8
) (
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic             frame_end,
   input  logic [CNT_W-1:0] frame_bits,
   input  logic             addr_chk_en,
   input  logic             len_chk_en,
   output logic             addr_evt,
   output logic             len_evt
);
   localparam logic [AW-1:0]    LAST_A   = AW'(LAST);
   localparam logic [CNT_W-1:0] BYTE_MSK = CNT_W'(7);

   always_comb begin
      addr_evt = addr_chk_en && (wr_en || rd_en) && (addr > LAST_A);
      len_evt  = len_chk_en && frame_end && ((frame_bits & BYTE_MSK) != '0);
   end
endmodule

// File: rtl/rf_status.sv
module rf_status
   import rf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       ev_supply_low,
   input  logic       ev_link_crc,
   input  logic       ev_cfg_crc,
   input  logic       ev_conv_fault,
   input  logic       ev_addr_bad,
   input  logic       ev_len_bad,
   input  logic       w1c_en,
   input  logic [7:0] w1c_data,
   output stat_t      stat,
   output logic       blocked
);
   logic [7:0] clr_mask;
   stat_t      nxt;

   assign clr_mask = w1c_en ? w1c_data : 8'h00;

   always_comb begin
      nxt            = stat;
      nxt.rsvd       = 1'b0;
      nxt.supply_low = ev_supply_low | (stat.supply_low & ~clr_mask[6]);
      nxt.rst_seen   = stat.rst_seen & ~clr_mask[5];
      nxt.link_crc   = ev_link_crc | (stat.link_crc & ~clr_mask[4]);
      nxt.cfg_crc    = ev_cfg_crc | (stat.cfg_crc & ~clr_mask[3]);
      nxt.conv_fault = ev_conv_fault | stat.conv_fault;
      nxt.addr_bad   = ev_addr_bad | (stat.addr_bad & ~clr_mask[1]);
      nxt.len_bad    = ev_len_bad | (stat.len_bad & ~clr_mask[0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stat <= stat_t'(STAT_RST);
      else if (clr) stat <= stat_t'(STAT_RST);
      else          stat <= nxt;
   end

   assign blocked = stat.link_crc | stat.addr_bad | stat.len_bad;
endmodule

// File: rtl/rf_store.sv
module rf_store
   import rf_pkg::*;
#(
   parameter int LAST      = 80,
   parameter int CH_BASE   = 17,
   parameter int CH_STRIDE = 8,
   parameter int GAIN_OFS  = 5,
   localparam int FLAT_W   = (LAST + 1) * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [7:0]        wdata,
   input  logic [AW-1:0]     raddr,
   output logic [7:0]        rbyte,
   output logic [FLAT_W-1:0] flat
);
   function automatic logic is_rw(int a);
      return (a == CRC_HI_A) || (a == CRC_LO_A) ||
             (a >= GEN_LO_A && a <= GEN_HI_A) ||
             (a >= CH_BASE && a <= LAST);
   endfunction

   function automatic logic [7:0] rst_val(int a);
      if (a == int'(A_GCFG2)) return GCFG2_RST;
      if (a == int'(A_GCFG3)) return GCFG3_RST;
      if (a >= CH_BASE && ((a - CH_BASE) % CH_STRIDE) == GAIN_OFS) return GAIN_RST;
      return 8'h00;
   endfunction

   logic [7:0] bytes_q [0:LAST];

   for (genvar a = 0; a <= LAST; a++) begin : g_byte
      if (is_rw(a)) begin : g_rw
         localparam logic [7:0] RV = rst_val(a);
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= RV;
            else if (clr)                       q <= RV;
            else if (we && waddr == AW'(a))     q <= wdata;
         end
         assign bytes_q[a] = q;
      end else begin : g_none
         assign bytes_q[a] = 8'h00;
      end
      assign flat[a*8 +: 8] = bytes_q[a];
   end

   always_comb begin
      rbyte = 8'h00;
      for (int i = 0; i <= LAST; i++)
         if (raddr == AW'(i)) rbyte = bytes_q[i];
   end
endmodule

// File: rtl/guarded_regfile.sv
module guarded_regfile
   import rf_pkg::*;
#(
   parameter int          NUM_CH    = 8,
   parameter int          CH_BASE   = 17,
   parameter int          CH_STRIDE = 8,
   parameter int          GAIN_OFS  = 5,
   parameter int          CNT_W     = 8,
   parameter logic [7:0]  ID_CODE   = 8'h5A,
   parameter logic [7:0]  REV_CODE  = 8'h01,
   localparam int         LAST      = CH_BASE + NUM_CH * CH_STRIDE - 1,
   localparam int         FLAT_W    = (LAST + 1) * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              frame_end,
   input  logic [CNT_W-1:0]  frame_bits,
   input  logic              ev_supply_low,
   input  logic              ev_link_crc,
   input  logic              ev_cfg_crc,
   input  logic              ev_conv_fault,
   output logic              start_pulse,
   output logic              stop_pulse,
   output logic [FLAT_W-1:0] regs_flat
);
   if (NUM_CH < 1)               begin : g_bad_ch   $error("NUM_CH must be at least 1"); end
   if (LAST > 255)               begin : g_bad_map  $error("register map exceeds address width"); end
   if (CH_STRIDE <= GAIN_OFS)    begin : g_bad_ofs  $error("gain offset outside channel stride"); end
   if (CH_BASE <= GEN_HI_A)      begin : g_bad_base $error("channel base overlaps general block"); end
   if (CNT_W < 3)                begin : g_bad_cnt  $error("frame count too narrow"); end

   stat_t      stat;
   logic       blocked;
   logic       addr_evt, len_evt;
   logic       wr_ok, ctrl_wr, soft_clr, store_we;
   logic [7:0] rd_mux, store_byte;

   assign wr_ok    = wr_en && (!blocked || addr == A_STAT);
   assign ctrl_wr  = wr_ok && addr == A_CTRL;
   assign soft_clr = ctrl_wr && wdata[7:2] == SW_KEY && wdata[1:0] == 2'b00;
   assign store_we = wr_ok && addr != A_STAT && addr != A_CTRL;

   rf_guard #(.LAST(LAST), .CNT_W(CNT_W)) u_guard (
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .frame_end   (frame_end),
      .frame_bits  (frame_bits),
      .addr_chk_en (regs_flat[int'(A_GCFG3)*8 + CHK_ADDR_BIT]),
      .len_chk_en  (regs_flat[int'(A_GCFG3)*8 + CHK_LEN_BIT]),
      .addr_evt    (addr_evt),
      .len_evt     (len_evt)
   );

   rf_status u_status (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr           (soft_clr),
      .ev_supply_low (ev_supply_low),
      .ev_link_crc   (ev_link_crc),
      .ev_cfg_crc    (ev_cfg_crc),
      .ev_conv_fault (ev_conv_fault),
      .ev_addr_bad   (addr_evt),
      .ev_len_bad    (len_evt),
      .w1c_en        (wr_en && addr == A_STAT),
      .w1c_data      (wdata),
      .stat          (stat),
      .blocked       (blocked)
   );

   rf_store #(
      .LAST      (LAST),
      .CH_BASE   (CH_BASE),
      .CH_STRIDE (CH_STRIDE),
      .GAIN_OFS  (GAIN_OFS)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_clr),
      .we    (store_we),
      .waddr (addr),
      .wdata (wdata),
      .raddr (addr),
      .rbyte (store_byte),
      .flat  (regs_flat)
   );

   always_comb begin
      unique case (addr)
         A_ID:    rd_mux = ID_CODE;
         A_REV:   rd_mux = REV_CODE;
         A_STAT:  rd_mux = stat;
         A_CTRL:  rd_mux = 8'h00;
         default: rd_mux = store_byte;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata       <= 8'h00;
         start_pulse <= 1'b0;
         stop_pulse  <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         start_pulse <= ctrl_wr && wdata[1];
         stop_pulse  <= ctrl_wr && wdata[0];
      end
   end
endmodule

// File: rtl/guarded_regfile_chk.sv
module guarded_regfile_chk #(
   parameter int LAST   = 80,
   parameter int FLAT_W = 648
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [7:0]        addr,
   input logic [7:0]        wdata,
   input logic [7:0]        stat,
   input logic              blocked,
   input logic              soft_clr,
   input logic              start_pulse,
   input logic              stop_pulse,
   input logic [FLAT_W-1:0] regs_flat
);
   localparam logic [7:0] LAST_A = 8'(LAST);

   AST_SOFT_RST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_clr) |-> stat == 8'h60); // R10

   AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (blocked && wr_en && addr != 8'h02) |=> $stable(regs_flat)); // R9

   AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> $past(wr_en && addr == 8'h07 && wdata[1])); // R11

   AST_STOP_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> $past(wr_en && addr == 8'h07 && wdata[0])); // R11

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[2] && !soft_clr) |=> stat[2]); // R5

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[7]); // R5

   AST_ADDR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en && addr > LAST_A && regs_flat[8'h0A*8 + 3] && !soft_clr) |-> stat[1]); // R7
endmodule

bind guarded_regfile guarded_regfile_chk #(.LAST(LAST), .FLAT_W(FLAT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .addr        (addr),
   .wdata       (wdata),
   .stat        (stat),
   .blocked     (blocked),
   .soft_clr    (soft_clr),
   .start_pulse (start_pulse),
   .stop_pulse  (stop_pulse),
   .regs_flat   (regs_flat)
);

// File: tb/guarded_regfile_test.sv
module guarded_regfile_test;
   localparam int FLAT_W = 81 * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] addr = '0, wdata = '0;
   logic [7:0] rdata;
   logic frame_end = 1'b0;
   logic [7:0] frame_bits = '0;
   logic ev_supply_low = 1'b0, ev_link_crc = 1'b0, ev_cfg_crc = 1'b0, ev_conv_fault = 1'b0;
   logic start_pulse, stop_pulse;
   logic [FLAT_W-1:0] regs_flat;

   int compared = 0;
   int mismatched = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];
   logic  pend = 1'b0;

   always #10 clk = ~clk;

   guarded_regfile uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .frame_end(frame_end), .frame_bits(frame_bits),
      .ev_supply_low(ev_supply_low), .ev_link_crc(ev_link_crc),
      .ev_cfg_crc(ev_cfg_crc), .ev_conv_fault(ev_conv_fault),
      .start_pulse(start_pulse), .stop_pulse(stop_pulse), .regs_flat(regs_flat)
   );

   always @(posedge clk) pend <= rd_en;

   // monitor: pops expected bytes as read data appears
   always @(negedge clk) begin
      if (pend) begin
         item_t it;
         compared++;
         if (sb_q.size() == 0) begin
            mismatched++;
            $display("FAIL scoreboard empty: actual %02h expected none", rdata);
         end else begin
            it = sb_q.pop_front();
            if (rdata !== it.exp) begin
               mismatched++;
               $display("FAIL %s: actual %02h expected %02h", it.tag, rdata, it.exp);
            end
         end
      end
   end

   task automatic chk_bit(input logic act, input logic exp, input string tag);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic with_low);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1; ev_supply_low = with_low;
      @(negedge clk);
      wr_en = 1'b0; ev_supply_low = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_supply_low = 1'b1;
         1: ev_link_crc   = 1'b1;
         2: ev_cfg_crc    = 1'b1;
         default: ev_conv_fault = 1'b1;
      endcase
      @(negedge clk);
      ev_supply_low = 1'b0; ev_link_crc = 1'b0; ev_cfg_crc = 1'b0; ev_conv_fault = 1'b0;
   endtask

   task automatic frame(input logic [7:0] n);
      @(negedge clk);
      frame_end = 1'b1; frame_bits = n;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      chk_bit(start_pulse, 1'b0, "R1 start idle");
      rd(8'h02, 8'h60, "R1 status");
      rd(8'h09, 8'h04, "R1 reg09");
      rd(8'h0A, 8'h80, "R1 reg0A");
      rd(8'h16, 8'h40, "R1 ch0 gain hi");
      rd(8'h4E, 8'h40, "R1 ch7 gain hi");
      rd(8'h11, 8'h00, "R1 ch0 cfg");
      rd(8'h00, 8'h5A, "R1 id");
      rd(8'h01, 8'h01, "R1 rev");
      // R2 write/read
      wr(8'h08, 8'h2A, 1'b0);
      wr(8'h31, 8'h5C, 1'b0);
      wr(8'h05, 8'hF0, 1'b0);
      rd(8'h08, 8'h2A, "R2 reg08");
      rd(8'h31, 8'h5C, "R2 reg31");
      rd(8'h05, 8'hF0, "R2 reg05");
      // R3 unlisted
      wr(8'h03, 8'h77, 1'b0);
      rd(8'h03, 8'h00, "R3 reg03");
      rd(8'h04, 8'h00, "R3 reg04");
      rd(8'h60, 8'h00, "R3 beyond map");
      rd(8'h02, 8'h60, "R7 check disabled no flag");
      // R4 write-one-to-clear
      wr(8'h02, 8'h40, 1'b0);
      rd(8'h02, 8'h20, "R4 clear bit6");
      wr(8'h02, 8'h00, 1'b0);
      rd(8'h02, 8'h20, "R4 zero keeps");
      wr(8'h02, 8'h20, 1'b0);
      rd(8'h02, 8'h00, "R4 clear bit5");
      // R6 events
      pulse(0);
      rd(8'h02, 8'h40, "R6 supply low");
      pulse(2);
      rd(8'h02, 8'h48, "R6 cfg crc");
      wr(8'h02, 8'h48, 1'b0);
      pulse(3);
      rd(8'h02, 8'h04, "R6 conv fault");
      // R5 fault not clearable
      wr(8'h02, 8'hFF, 1'b0);
      rd(8'h02, 8'h04, "R5 fault sticky");
      // R9 link crc lock
      pulse(1);
      rd(8'h02, 8'h14, "R6 link crc");
      wr(8'h08, 8'h11, 1'b0);
      rd(8'h08, 8'h2A, "R9 locked write");
      wr(8'h07, 8'h02, 1'b0);
      chk_bit(start_pulse, 1'b0, "R9 locked control");
      wr(8'h02, 8'h10, 1'b0);
      rd(8'h02, 8'h04, "R4 clear link");
      wr(8'h08, 8'h11, 1'b0);
      rd(8'h08, 8'h11, "R9 unlocked write");
      // R7 address check
      wr(8'h0A, 8'h8C, 1'b0);
      rd(8'h51, 8'h00, "R3 first out of range");
      rd(8'h02, 8'h06, "R7 addr flag");
      wr(8'h08, 8'h33, 1'b0);
      rd(8'h08, 8'h11, "R9 addr lock");
      wr(8'h02, 8'h02, 1'b0);
      rd(8'h02, 8'h04, "R4 clear addr");
      // R8 frame length
      frame(8'd16);
      rd(8'h02, 8'h04, "R8 whole bytes");
      frame(8'd13);
      rd(8'h02, 8'h05, "R8 short frame");
      wr(8'h0C, 8'h99, 1'b0);
      rd(8'h0C, 8'h00, "R9 length lock");
      wr(8'h02, 8'h01, 1'b0);
      rd(8'h02, 8'h04, "R4 clear len");
      // R4 set wins over clear
      pulse(0);
      wr(8'h02, 8'h40, 1'b1);
      rd(8'h02, 8'h44, "R4 set beats clear");
      wr(8'h02, 8'h40, 1'b0);
      // R9 cfg crc does not lock
      pulse(2);
      wr(8'h09, 8'h16, 1'b0);
      rd(8'h09, 8'h16, "R9 cfg crc no lock");
      wr(8'h02, 8'h08, 1'b0);
      // R11 command pulses
      wr(8'h07, 8'h03, 1'b0);
      chk_bit(start_pulse, 1'b1, "R11 start pulse");
      chk_bit(stop_pulse, 1'b1, "R11 stop pulse");
      @(negedge clk);
      chk_bit(start_pulse, 1'b0, "R11 start ends");
      chk_bit(stop_pulse, 1'b0, "R11 stop ends");
      rd(8'h07, 8'h00, "R11 ctrl reads zero");
      // R10 key with start: no reset
      wr(8'h07, 8'h5A, 1'b0);
      chk_bit(start_pulse, 1'b1, "R10 key plus start pulses");
      rd(8'h08, 8'h11, "R10 no reset with start");
      // R10 soft reset
      wr(8'h07, 8'h58, 1'b0);
      chk_bit(start_pulse, 1'b0, "R10 reset no start");
      rd(8'h02, 8'h60, "R10 status");
      rd(8'h08, 8'h00, "R10 reg08");
      rd(8'h0A, 8'h80, "R10 reg0A");
      rd(8'h09, 8'h04, "R10 reg09");
      rd(8'h36, 8'h40, "R10 ch4 gain hi");
      rd(8'h05, 8'h00, "R10 reg05");
      rd(8'h31, 8'h00, "R10 reg31");
      rd(8'h70, 8'h00, "R7 checks off after reset");
      rd(8'h02, 8'h60, "R7 no flag when off");
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         compared++; mismatched++;
         $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule